// File: doc/BRIEF.md
# Three-Port Wormhole Header Router

This block steers packets from three incoming link streams to four outgoing streams: the three link outputs and the local node. The first data character of every packet names its destination. The router compares that byte with four programmable 8-bit addresses, one for each link and one for the local node. It then deletes the byte and passes the rest of the packet, including its end marker, to the chosen output. Only one packet holds an output at a time, and it keeps that output until its end marker has passed.

A header that matches no usable address still gets delivered. This includes a header that names the link the packet arrived on. Such a packet goes to the local output, and the router sets a sticky error flag. The flag is gated by a mask bit to form the interrupt. When several inputs want the same output, the output is granted in rotation at packet boundaries. A stalled output holds back only the input that is currently routed to it.

Top module: `wr_router`

## Requirements
- R1: After reset, every out_valid bit is 0, irq is 0 and every in_ready bit is 1.
- R2: The first non-marker character of a packet is always accepted at once and never appears on any output. The characters after it appear unchanged and in order.
- R3: A header equal to the address of a link other than the arrival link sends the packet to that link's output, with output index equal to the link index. No other output sees it.
- R4: A header equal to cfg_local_addr sends the packet to output index NUM_LINKS (the local output) and does not set the error flag. This address is checked first and wins over an equal link address.
- R5: A header that matches no address sends the packet to the local output and sets the error flag.
- R6: A header equal to the arrival link's own address is treated as unmatched. It goes to the local output and sets the error flag, and nothing appears on the arrival link's output.
- R7: A character with in_end=1 ends the packet and is forwarded with end=1 and its in_eep bit. EOP is eep=0 and EEP is eep=1. The output stays owned by the same input until that marker is accepted.
- R8: Packets competing for one output are never interleaved. Inputs with waiting packets are served in rotation, so two inputs streaming to one output alternate packet by packet.
- R9: While an output has out_ready=0, the input routed to it sees in_ready=0. Other inputs routed to other outputs keep flowing, and the stalled packet completes once out_ready returns.
- R10: The error flag stays set until irq_clr is 1 at a clock edge. irq equals the flag ANDed with irq_mask.
- R11: An end marker arriving where a header is expected (an empty packet) is consumed and appears on no output, and the next packet routes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_link_addr | input | NUM_LINKS*DATA_W | Address of each link, link i in bits [i*DATA_W +: DATA_W] |
| cfg_local_addr | input | DATA_W | Address of the local node |
| irq_mask | input | 1 | Interrupt enable for the error flag |
| irq_clr | input | 1 | Write-one clear of the error flag |
| in_valid | input | NUM_LINKS | Character present on each input |
| in_ready | output | NUM_LINKS | Character accepted on each input |
| in_data | input | NUM_LINKS*DATA_W | Character byte per input |
| in_end | input | NUM_LINKS | Character is an end marker |
| in_eep | input | NUM_LINKS | End marker is an error end (EEP) |
| out_valid | output | NUM_LINKS+1 | Character present per output, local last |
| out_ready | input | NUM_LINKS+1 | Sink accepts character per output |
| out_data | output | (NUM_LINKS+1)*DATA_W | Character byte per output |
| out_end | output | NUM_LINKS+1 | Output character is an end marker |
| out_eep | output | NUM_LINKS+1 | Output end marker is EEP |
| irq | output | 1 | Masked routing-error interrupt |

## Verification
Several properties are checked on every cycle:
- a waiting header is always taken;
- the count of forwarded body characters equals the count of output handshakes, which shows header deletion and no duplication;
- an output keeps its owner until its end marker passes;
- no input owns two outputs at once;
- the error flag is sticky and the interrupt respects its mask.

Which output a given address selects, the handling of the arrival link's own address and of empty packets, the alternation order under contention, and the isolation of a stalled output from unrelated traffic are shown only by the bench's directed scenarios.

// File: rtl/wr_pkg.sv
`timescale 1ns/1ps
package wr_pkg;
   typedef enum logic {
      ST_HDR  = 1'b0,
      ST_BODY = 1'b1
   } wr_state_e;
endpackage

// File: rtl/wr_decode.sv
`timescale 1ns/1ps
module wr_decode #(
   parameter int NUM_LINKS = 3,
   parameter int DATA_W    = 8,
   parameter int SELF      = 0,
   parameter int PW        = $clog2(NUM_LINKS + 1)
) (
   input  logic [DATA_W-1:0]           hdr,
   input  logic [NUM_LINKS*DATA_W-1:0] link_addr,
   input  logic [DATA_W-1:0]           local_addr,
   output logic [PW-1:0]               dest,
   output logic                        miss
);
   always_comb begin
      dest = PW'(NUM_LINKS);
      miss = 1'b1;
      // descending scan: lowest matching link wins
      for (int j = NUM_LINKS - 1; j >= 0; j--) begin
         if (j != SELF && hdr == link_addr[j*DATA_W +: DATA_W]) begin
            dest = PW'(j);
            miss = 1'b0;
         end
      end
      if (hdr == local_addr) begin
         dest = PW'(NUM_LINKS);
         miss = 1'b0;
      end
   end
endmodule

// File: rtl/wr_arbiter.sv
`timescale 1ns/1ps
module wr_arbiter #(
   parameter int NREQ = 3,
   parameter int IW   = $clog2(NREQ)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req,
   input  logic            pkt_done,
   output logic            busy,
   output logic [IW-1:0]   owner
);
   logic [IW-1:0] ptr_q;
   logic [IW-1:0] pick;
   logic          any;

   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int k = NREQ - 1; k >= 0; k--) begin
         automatic int idx = int'(ptr_q) + k;
         if (idx >= NREQ) idx = idx - NREQ;
         if (req[idx]) begin
            pick = IW'(idx);
            any  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         owner <= '0;
         ptr_q <= '0;
      end else if (busy) begin
         if (pkt_done) busy <= 1'b0;
      end else if (any) begin
         busy  <= 1'b1;
         owner <= pick;
         ptr_q <= (int'(pick) == NREQ - 1) ? '0 : pick + 1'b1;
      end
   end
endmodule

// File: rtl/wr_router.sv
`timescale 1ns/1ps
module wr_router
   import wr_pkg::*;
#(
   parameter int NUM_LINKS = 3,
   parameter int DATA_W    = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_LINKS*DATA_W-1:0]       cfg_link_addr,
   input  logic [DATA_W-1:0]                 cfg_local_addr,
   input  logic                              irq_mask,
   input  logic                              irq_clr,
   input  logic [NUM_LINKS-1:0]              in_valid,
   output logic [NUM_LINKS-1:0]              in_ready,
   input  logic [NUM_LINKS*DATA_W-1:0]       in_data,
   input  logic [NUM_LINKS-1:0]              in_end,
   input  logic [NUM_LINKS-1:0]              in_eep,
   output logic [NUM_LINKS:0]                out_valid,
   input  logic [NUM_LINKS:0]                out_ready,
   output logic [(NUM_LINKS+1)*DATA_W-1:0]   out_data,
   output logic [NUM_LINKS:0]                out_end,
   output logic [NUM_LINKS:0]                out_eep,
   output logic                              irq
);
   localparam int NPORT = NUM_LINKS + 1;
   localparam int PW    = $clog2(NPORT);
   localparam int LW    = $clog2(NUM_LINKS);

   if (NUM_LINKS < 2) begin : g_bad_links
      $error("wr_router: NUM_LINKS must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("wr_router: DATA_W must be at least 2");
   end

   wr_state_e             st_q     [NUM_LINKS];
   logic [PW-1:0]         dest_q   [NUM_LINKS];
   logic [PW-1:0]         dec_dest [NUM_LINKS];
   logic [NUM_LINKS-1:0]  dec_miss;
   logic [NUM_LINKS-1:0]  hdr_phase;
   logic [NUM_LINKS-1:0]  hdr_fire;
   logic [NUM_LINKS-1:0]  hdr_miss;
   logic [NUM_LINKS-1:0]  gnt;
   logic [NPORT-1:0]      arb_busy;
   logic [NPORT-1:0]      out_done;
   logic [LW-1:0]         arb_owner [NPORT];
   logic [NPORT*LW-1:0]   arb_owner_flat;
   logic                  irq_flag;

   // ---------------- input side ----------------
   for (genvar i = 0; i < NUM_LINKS; i++) begin : g_in
      wr_decode #(
         .NUM_LINKS (NUM_LINKS),
         .DATA_W    (DATA_W),
         .SELF      (i),
         .PW        (PW)
      ) u_dec (
         .hdr        (in_data[i*DATA_W +: DATA_W]),
         .link_addr  (cfg_link_addr),
         .local_addr (cfg_local_addr),
         .dest       (dec_dest[i]),
         .miss       (dec_miss[i])
      );

      assign hdr_phase[i] = (st_q[i] == ST_HDR);
      assign hdr_fire[i]  = hdr_phase[i] & in_valid[i] & ~in_end[i];
      assign hdr_miss[i]  = hdr_fire[i] & dec_miss[i];
      assign gnt[i]       = arb_busy[dest_q[i]] && (arb_owner[dest_q[i]] == LW'(i));
      assign in_ready[i]  = hdr_phase[i] | (gnt[i] & out_ready[dest_q[i]]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[i]   <= ST_HDR;
            dest_q[i] <= '0;
         end else if (hdr_fire[i]) begin
            st_q[i]   <= ST_BODY;
            dest_q[i] <= dec_dest[i];
         end else if (!hdr_phase[i] && in_valid[i] && in_ready[i] && in_end[i]) begin
            st_q[i]   <= ST_HDR;
         end
      end
   end

   // ---------------- output side ----------------
   for (genvar o = 0; o < NPORT; o++) begin : g_out
      logic [NUM_LINKS-1:0] req;
      for (genvar i = 0; i < NUM_LINKS; i++) begin : g_req
         assign req[i] = !hdr_phase[i] && (dest_q[i] == PW'(o));
      end

      wr_arbiter #(
         .NREQ (NUM_LINKS),
         .IW   (LW)
      ) u_arb (
         .clk      (clk),
         .rst_n    (rst_n),
         .req      (req),
         .pkt_done (out_done[o]),
         .busy     (arb_busy[o]),
         .owner    (arb_owner[o])
      );

      assign out_valid[o]                  = arb_busy[o] & in_valid[arb_owner[o]];
      assign out_data[o*DATA_W +: DATA_W]  = in_data[arb_owner[o]*DATA_W +: DATA_W];
      assign out_end[o]                    = in_end[arb_owner[o]];
      assign out_eep[o]                    = in_eep[arb_owner[o]];
      assign out_done[o]                   = out_valid[o] & out_ready[o] & out_end[o];
      assign arb_owner_flat[o*LW +: LW]    = arb_owner[o];
   end

   // ---------------- error interrupt ----------------
   always_ff @(posedge clk) begin
      if (!rst_n)           irq_flag <= 1'b0;
      else if (|hdr_miss)   irq_flag <= 1'b1;
      else if (irq_clr)     irq_flag <= 1'b0;
   end

   assign irq = irq_flag & irq_mask;
endmodule

// File: rtl/wr_router_chk.sv
`timescale 1ns/1ps
module wr_router_chk #(
   parameter int NL = 3,
   parameter int NP = NL + 1,
   parameter int LW = $clog2(NL)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NL-1:0]   in_valid,
   input logic [NL-1:0]   in_ready,
   input logic [NL-1:0]   hdr_phase,
   input logic [NP-1:0]   out_valid,
   input logic [NP-1:0]   out_ready,
   input logic [NP-1:0]   out_end,
   input logic [NP-1:0]   busy,
   input logic [NP*LW-1:0] owner_flat,
   input logic            irq_flag,
   input logic            irq_clr,
   input logic            irq_mask,
   input logic            irq
);
   for (genvar i = 0; i < NL; i++) begin : g_in_chk
      AST_HDR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid[i] && hdr_phase[i] |-> in_ready[i]);  // R2

      logic [NP-1:0] owns;
      for (genvar o = 0; o < NP; o++) begin : g_own
         assign owns[o] = busy[o] && (owner_flat[o*LW +: LW] == LW'(i));
      end
      AST_SINGLE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(owns) <= 1);  // R8
   end

   AST_BEAT_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_valid & in_ready & ~hdr_phase) == $countones(out_valid & out_ready));  // R2

   for (genvar o = 0; o < NP; o++) begin : g_out_chk
      AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         busy[o] && !(out_valid[o] && out_ready[o] && out_end[o])
         |=> busy[o] && $stable(owner_flat[o*LW +: LW]));  // R7
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag && !irq_clr |=> irq_flag);  // R10

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_mask && irq_flag);  // R10
endmodule

bind wr_router wr_router_chk #(
   .NL (NUM_LINKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .hdr_phase  (hdr_phase),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_end    (out_end),
   .busy       (arb_busy),
   .owner_flat (arb_owner_flat),
   .irq_flag   (irq_flag),
   .irq_clr    (irq_clr),
   .irq_mask   (irq_mask),
   .irq        (irq)
);

// File: tb/wr_router_bench.sv
`timescale 1ns/1ps
module wr_router_bench;
   localparam int NL = 3;
   localparam int NP = 4;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NL*DW-1:0] cfg_link_addr = {8'h12, 8'h11, 8'h10};
   logic [DW-1:0]    cfg_local_addr = 8'h20;
   logic             irq_mask = 1'b1;
   logic             irq_clr = 1'b0;
   logic [NL-1:0]    in_valid, in_ready, in_end, in_eep;
   logic [NL*DW-1:0] in_data;
   logic [NP-1:0]    out_valid, out_end, out_eep;
   logic [NP-1:0]    out_ready = '1;
   logic [NP*DW-1:0] out_data;
   logic             irq;

   logic       dv [NL];
   logic       de [NL];
   logic       dp [NL];
   logic [7:0] dd [NL];

   for (genvar i = 0; i < NL; i++) begin : g_drv
      assign in_valid[i]         = dv[i];
      assign in_end[i]           = de[i];
      assign in_eep[i]           = dp[i];
      assign in_data[i*DW +: DW] = dd[i];
   end

   wr_router #(.NUM_LINKS(NL), .DATA_W(DW)) u_wr_router (
      .clk(clk), .rst_n(rst_n), .cfg_link_addr(cfg_link_addr),
      .cfg_local_addr(cfg_local_addr), .irq_mask(irq_mask), .irq_clr(irq_clr),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_end(in_end), .in_eep(in_eep), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_end(out_end),
      .out_eep(out_eep), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   logic [9:0] rx [NP][64];
   int rx_cnt [NP];

   // output monitor: records each handshake that completes at the coming edge
   initial begin
      for (int o = 0; o < NP; o++) rx_cnt[o] = 0;
      forever begin
         @(negedge clk);
         #1;
         for (int o = 0; o < NP; o++) begin
            if (out_valid[o] && out_ready[o]) begin
               if (rx_cnt[o] < 64)
                  rx[o][rx_cnt[o]] = {out_end[o], out_eep[o], out_data[o*DW +: DW]};
               rx_cnt[o]++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_rx();
      for (int o = 0; o < NP; o++) rx_cnt[o] = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a falling edge; returns at the falling edge after acceptance
   task automatic send_char(input int i, input logic [7:0] d, input logic e, input logic p);
      bit r;
      dv[i] = 1'b1; dd[i] = d; de[i] = e; dp[i] = p;
      do begin
         #1;
         r = in_ready[i];
         @(negedge clk);
      end while (!r);
   endtask

   task automatic send_pkt(input int i, input logic [7:0] hdr, input int n,
                           input logic [7:0] tag, input logic eep);
      @(negedge clk);
      send_char(i, hdr, 1'b0, 1'b0);
      for (int k = 0; k < n; k++) send_char(i, tag + 8'(k), 1'b0, 1'b0);
      send_char(i, 8'h00, 1'b1, eep);
      dv[i] = 1'b0; de[i] = 1'b0;
   endtask

   // compare n body bytes plus the end marker at output o
   task automatic chk_pkt(input int o, input int n, input logic [7:0] tag,
                          input logic eep, input string req);
      int bad = -1;
      for (int k = 0; k < n; k++)
         if (rx[o][k] != {2'b00, tag + 8'(k)}) bad = k;
      chk(bad < 0, req, (bad < 0) ? 0 : int'(rx[o][bad][7:0]),
          (bad < 0) ? 0 : int'(tag) + bad);
      chk(rx[o][n][9:8] == {1'b1, eep}, req, int'(rx[o][n][9:8]), int'({1'b1, eep}));
   endtask

   task automatic t_reset();
      chk(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);
      chk(in_ready == '1, "R1 in_ready", int'(in_ready), 7);
   endtask

   task automatic t_link();
      clear_rx();
      send_pkt(0, 8'h11, 3, 8'h00, 1'b0);
      idle(8);
      chk(rx_cnt[1] == 4, "R3 count at link1", rx_cnt[1], 4);
      chk(rx_cnt[0] + rx_cnt[2] + rx_cnt[3] == 0, "R3 other outputs", rx_cnt[0] + rx_cnt[2] + rx_cnt[3], 0);
      chk_pkt(1, 3, 8'h00, 1'b0, "R2/R7 header stripped, EOP kept");
   endtask

   task automatic t_local();
      clear_rx();
      send_pkt(2, 8'h20, 2, 8'h30, 1'b0);
      idle(8);
      chk(rx_cnt[3] == 3, "R4 count at local", rx_cnt[3], 3);
      chk_pkt(3, 2, 8'h30, 1'b0, "R4 local payload");
      chk(irq == 1'b0, "R4 no error", int'(irq), 0);
   endtask

   task automatic t_miss();
      clear_rx();
      send_pkt(1, 8'h55, 2, 8'h08, 1'b0);
      idle(8);
      chk(rx_cnt[3] == 3, "R5 unmatched to local", rx_cnt[3], 3);
      chk(irq == 1'b1, "R5 error raised", int'(irq), 1);
      irq_mask = 1'b0;
      #1 chk(irq == 1'b0, "R10 masked", int'(irq), 0);
      idle(3);
      irq_mask = 1'b1;
      #1 chk(irq == 1'b1, "R10 sticky", int'(irq), 1);
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      #1 chk(irq == 1'b0, "R10 cleared", int'(irq), 0);
   endtask

   task automatic t_own();
      clear_rx();
      send_pkt(0, 8'h10, 2, 8'h18, 1'b0);
      idle(8);
      chk(rx_cnt[3] == 3, "R6 own address to local", rx_cnt[3], 3);
      chk(rx_cnt[0] == 0, "R6 nothing on own link", rx_cnt[0], 0);
      chk(irq == 1'b1, "R6 error raised", int'(irq), 1);
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic t_eep();
      clear_rx();
      send_pkt(1, 8'h12, 1, 8'h2a, 1'b1);
      idle(8);
      chk(rx_cnt[2] == 2, "R7 EEP packet count", rx_cnt[2], 2);
      chk_pkt(2, 1, 8'h2a, 1'b1, "R7 EEP forwarded");
   endtask

   task automatic t_empty();
      clear_rx();
      @(negedge clk);
      send_char(0, 8'h11, 1'b1, 1'b1);
      dv[0] = 1'b0; de[0] = 1'b0;
      send_pkt(0, 8'h11, 2, 8'h05, 1'b0);
      idle(8);
      chk(rx_cnt[1] == 3, "R11 empty packet dropped", rx_cnt[1], 3);
      chk_pkt(1, 2, 8'h05, 1'b0, "R11 next packet intact");
   endtask

   task automatic t_contend();
      int cur, prev, bad_mix, bad_alt, pkts;
      clear_rx();
      fork
         begin
            send_pkt(0, 8'h11, 3, 8'h00, 1'b0);
            send_pkt(0, 8'h11, 3, 8'h10, 1'b0);
         end
         begin
            send_pkt(2, 8'h11, 3, 8'h80, 1'b0);
            send_pkt(2, 8'h11, 3, 8'h90, 1'b0);
         end
      join
      idle(8);
      chk(rx_cnt[1] == 16, "R8 all beats delivered", rx_cnt[1], 16);
      cur = -1; prev = -1; bad_mix = 0; bad_alt = 0; pkts = 0;
      for (int k = 0; k < rx_cnt[1] && k < 64; k++) begin
         if (rx[1][k][9]) begin
            if (pkts > 0 && cur == prev) bad_alt++;
            prev = cur; cur = -1; pkts++;
         end else if (cur < 0) begin
            cur = int'(rx[1][k][7:6]);
         end else if (cur != int'(rx[1][k][7:6])) begin
            bad_mix++;
         end
      end
      chk(bad_mix == 0, "R8 no interleaving", bad_mix, 0);
      chk(bad_alt == 0 && pkts == 4, "R8 alternation", bad_alt, 0);
   endtask

   task automatic t_back();
      clear_rx();
      @(negedge clk); out_ready[1] = 1'b0;
      fork
         send_pkt(0, 8'h11, 3, 8'h01, 1'b0);
      join_none
      send_pkt(2, 8'h20, 3, 8'h21, 1'b0);
      idle(4);
      chk(rx_cnt[3] == 4, "R9 unrelated traffic flows", rx_cnt[3], 4);
      chk(rx_cnt[1] == 0, "R9 stalled output silent", rx_cnt[1], 0);
      #1 chk(in_ready[0] == 1'b0, "R9 routed input stalled", int'(in_ready[0]), 0);
      @(negedge clk); out_ready[1] = 1'b1;
      wait fork;
      idle(8);
      chk(rx_cnt[1] == 4, "R9 stalled packet completes", rx_cnt[1], 4);
      chk_pkt(1, 3, 8'h01, 1'b0, "R9 stalled payload");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) begin
         dv[i] = 1'b0; de[i] = 1'b0; dp[i] = 1'b0; dd[i] = 8'h00;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_link();
      t_local();
      t_miss();
      t_own();
      t_eep();
      t_empty();
      t_contend();
      t_back();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule